// File: doc/BRIEF.md
# Two-Wire Bit Shifter with Edge Counter

This block is the bit-level engine of a host-driven two-wire bus master. An eight-bit data register shifts one bit per bus clock period, most significant bit first. The top bit of the register drives the data line. Bits read from the data line enter at the least significant end. A four-bit counter steps on every clock-line edge, rising or falling. When it wraps it raises an overflow flag, which the host polls to learn that a transfer has finished. A preload of 0 gives a whole byte of 16 edges. A preload of 14 gives a single acknowledge bit of 2 edges. Both use the same shift path.

The host drives the block with single-cycle strobes. It can write the data register and write a status word that clears flags and loads the counter in one operation. It can also invert the clock-line latch, force that latch to a level, and force the data line low for start and stop sequences. Both lines are modelled as open-drain outputs. The bus levels are read back through a synchroniser, so every count and every condition follows the real wire, including a clock held low by a slow target. The block also detects start and stop conditions and reports a data collision.

Top module: `tws_shift_unit`

## Requirements
- R1: After synchronous reset the data register reads 0xFF, the counter reads 0, all four flags are 0, and neither line is pulled low.
- R2: A falling data line while the clock line is high sets the start flag. The flag stays set until cleared.
- R3: A rising data line while the clock line is high sets the stop flag.
- R4: A status write loads the counter from stat_in[3:0]. In the same write, a 1 in stat_in[7], [6], [5] or [4] clears the start, overflow, stop or collision flag respectively. A 0 in one of those bits leaves the flag unchanged.
- R5: The counter increments by one on every rising and every falling edge of the synchronised clock line, modulo 16.
- R6: The overflow flag sets on the edge that takes the counter from 15 to 0. After a preload of 0 it sets on the 16th edge and not before.
- R7: The data pin is pulled low only when sda_out_en is 1 and either data bit 7 is 0 or sda_force_low is 1. With sda_out_en at 0 the pin is released.
- R8: The bus data level is captured on each clock rising edge and shifted into bit 0 on the next falling edge, so after 16 edges the register holds the received byte, MSB first.
- R9: After a preload of 14, two edges shift the register left by one bit, bring in the bus bit, and set the overflow flag with the counter back at 0.
- R10: If sda_out_en is 1 and data bit 7 is 1, but the bus reads 0 at a rising clock edge, the collision flag sets.
- R11: The counter follows the bus clock level, not the block's own latch. While a target holds the clock low, a release strobe adds no count until the line actually rises.
- R12: Each clk_toggle strobe inverts the clock latch, and scl_drive_wr loads it from scl_drive_val. scl_oe_low is the complement of the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_wr | input | 1 | Strobe: load data register |
| data_in | input | 8 | Value for data register |
| stat_wr | input | 1 | Strobe: clear flags and load counter |
| stat_in | input | 8 | [7] start clr, [6] overflow clr, [5] stop clr, [4] collision clr, [3:0] counter preload |
| clk_toggle | input | 1 | Strobe: invert clock-line latch |
| scl_drive_wr | input | 1 | Strobe: force clock-line latch |
| scl_drive_val | input | 1 | Level for scl_drive_wr (1 = release) |
| sda_out_en | input | 1 | Enable data-line driver |
| sda_force_low | input | 1 | Host forces data line low |
| scl_in | input | 1 | Bus clock-line level |
| sda_in | input | 1 | Bus data-line level |
| scl_oe_low | output | 1 | Pull clock line low |
| sda_oe_low | output | 1 | Pull data line low |
| data_q | output | 8 | Data register |
| cnt_q | output | 4 | Edge counter |
| flag_start | output | 1 | Start condition seen |
| flag_ovf | output | 1 | Counter overflow |
| flag_stop | output | 1 | Stop condition seen |
| flag_coll | output | 1 | Data collision |

## Verification
A counter that is off by one edge shows up as an overflow flag rising one edge early or late, within a few cycles of that strobe. It also shows up as a received byte shifted by one position. A wrong capture or shift order shows up as a bit-reversed or misaligned byte once the transfer completes. A synchroniser or edge detector that looks at the latch instead of the wire is exposed at once by the stretched-clock case, where the count must not move. Flag set and clear faults appear at the next status observation after the condition is driven on the bus.

// File: rtl/tws_pkg.sv
package tws_pkg;
  // Sticky event flags of the shifter
  typedef struct packed {
    logic start;
    logic ovf;
    logic stop;
    logic coll;
  } tws_flags_t;
endpackage

// File: rtl/tws_sync.sv
// Multi-stage synchroniser; idle level of an open-drain bus is high
module tws_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '1;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tws_cond.sv
// Clock edge and bus condition detection on synchronised levels
module tws_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tws_core.sv
// Data shift register, edge counter and sticky flags
module tws_core
  import tws_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_wr,
  input  logic [DW-1:0] data_in,
  input  logic          stat_wr,
  input  logic [CW+3:0] stat_in,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic          sda_out_en,
  output logic [DW-1:0] data_q,
  output logic [CW-1:0] cnt_q,
  output tws_flags_t    flags_q
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic       samp_q;
  logic       edge_any;
  tws_flags_t flags_d;

  assign edge_any = scl_rise | scl_fall;

  always_comb begin
    flags_d = flags_q;
    if (stat_wr) begin
      if (stat_in[CW+3]) flags_d.start = 1'b0;
      if (stat_in[CW+2]) flags_d.ovf   = 1'b0;
      if (stat_in[CW+1]) flags_d.stop  = 1'b0;
      if (stat_in[CW])   flags_d.coll  = 1'b0;
    end
    if (start_det) flags_d.start = 1'b1;
    if (stop_det)  flags_d.stop  = 1'b1;
    if (edge_any && !stat_wr && cnt_q == CNT_MAX) flags_d.ovf = 1'b1;
    if (scl_rise && sda_out_en && data_q[DW-1] && !sda_s) flags_d.coll = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '1;
      cnt_q   <= '0;
      samp_q  <= 1'b1;
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
      if (scl_rise) samp_q <= sda_s;
      if (data_wr)       data_q <= data_in;
      else if (scl_fall) data_q <= {data_q[DW-2:0], samp_q};
      if (stat_wr)       cnt_q <= stat_in[CW-1:0];
      else if (edge_any) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tws_shift_unit.sv
// Top: pin drivers, synchroniser, condition detect and shift core
module tws_shift_unit
  import tws_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_wr,
  input  logic [DW-1:0] data_in,
  input  logic          stat_wr,
  input  logic [CW+3:0] stat_in,
  input  logic          clk_toggle,
  input  logic          scl_drive_wr,
  input  logic          scl_drive_val,
  input  logic          sda_out_en,
  input  logic          sda_force_low,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe_low,
  output logic          sda_oe_low,
  output logic [DW-1:0] data_q,
  output logic [CW-1:0] cnt_q,
  output logic          flag_start,
  output logic          flag_ovf,
  output logic          flag_stop,
  output logic          flag_coll
);
  logic       scl_lat;
  logic       sda_low_q;
  logic [1:0] bus_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  tws_flags_t flags;

  // Clock-line latch: 1 = released
  always_ff @(posedge clk) begin
    if (rst)               scl_lat <= 1'b1;
    else if (scl_drive_wr) scl_lat <= scl_drive_val;
    else if (clk_toggle)   scl_lat <= ~scl_lat;
  end

  // Registered data-line pull-down
  always_ff @(posedge clk) begin
    if (rst) sda_low_q <= 1'b0;
    else     sda_low_q <= sda_out_en & (~data_q[DW-1] | sda_force_low);
  end

  assign scl_oe_low = ~scl_lat;
  assign sda_oe_low = sda_low_q;

  tws_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (bus_s)
  );

  tws_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (bus_s[1]),
    .sda_s     (bus_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tws_core #(.DW(DW), .CW(CW)) u_core (
    .clk        (clk),
    .rst        (rst),
    .data_wr    (data_wr),
    .data_in    (data_in),
    .stat_wr    (stat_wr),
    .stat_in    (stat_in),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_s      (bus_s[0]),
    .sda_out_en (sda_out_en),
    .data_q     (data_q),
    .cnt_q      (cnt_q),
    .flags_q    (flags)
  );

  assign flag_start = flags.start;
  assign flag_ovf   = flags.ovf;
  assign flag_stop  = flags.stop;
  assign flag_coll  = flags.coll;
endmodule

// File: rtl/tws_shift_unit_chk.sv
module tws_shift_unit_chk #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          stat_wr,
  input logic          clk_toggle,
  input logic          scl_drive_wr,
  input logic          sda_out_en,
  input logic          scl_oe_low,
  input logic          sda_oe_low,
  input logic [DW-1:0] data_q,
  input logic [CW-1:0] cnt_q,
  input logic          flag_start,
  input logic          flag_ovf
);
  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (data_q == '1 && cnt_q == '0 && !flag_start && !flag_ovf));

  // R2: start flag is sticky without a status write
  p_start_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (flag_start && !stat_wr) |=> flag_start);

  // R5: counter holds or steps by one
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> (cnt_q == $past(cnt_q) || cnt_q == CW'($past(cnt_q) + 1'b1)));

  // R6: overflow rises only from the top count
  p_no_early_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    (!stat_wr && !flag_ovf && cnt_q != {CW{1'b1}}) |=> !flag_ovf);

  // R7: released driver never pulls data low
  p_sda_release_r7: assert property (@(posedge clk) disable iff (rst)
    !sda_out_en |=> !sda_oe_low);

  // R12: each toggle flips the clock pin
  p_scl_toggle_r12: assert property (@(posedge clk) disable iff (rst)
    (clk_toggle && !scl_drive_wr) |=> (scl_oe_low != $past(scl_oe_low)));
endmodule

bind tws_shift_unit tws_shift_unit_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stat_wr      (stat_wr),
  .clk_toggle   (clk_toggle),
  .scl_drive_wr (scl_drive_wr),
  .sda_out_en   (sda_out_en),
  .scl_oe_low   (scl_oe_low),
  .sda_oe_low   (sda_oe_low),
  .data_q       (data_q),
  .cnt_q        (cnt_q),
  .flag_start   (flag_start),
  .flag_ovf     (flag_ovf)
);

// File: tb/sim_tws_shift_unit.sv
`timescale 1ns/1ps
module sim_tws_shift_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       data_wr = 1'b0, stat_wr = 1'b0, clk_toggle = 1'b0;
  logic       scl_drive_wr = 1'b0, scl_drive_val = 1'b1;
  logic       sda_out_en = 1'b1, sda_force_low = 1'b0;
  logic [7:0] data_in = '0, stat_in = '0;
  logic       slave_scl = 1'b1, slave_sda = 1'b1;
  logic       scl_in, sda_in, scl_oe_low, sda_oe_low;
  logic [7:0] data_q;
  logic [3:0] cnt_q;
  logic       flag_start, flag_ovf, flag_stop, flag_coll;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  assign scl_in = ~scl_oe_low & slave_scl;
  assign sda_in = ~sda_oe_low & slave_sda;

  tws_shift_unit u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_toggle();
    clk_toggle = 1'b1; wait_n(1); clk_toggle = 1'b0; wait_n(8);
  endtask

  task automatic stat_write(input logic [7:0] v);
    stat_in = v; stat_wr = 1'b1; wait_n(1); stat_wr = 1'b0; wait_n(2);
  endtask

  task automatic data_write(input logic [7:0] v);
    data_in = v; data_wr = 1'b1; wait_n(1); data_wr = 1'b0; wait_n(3);
  endtask

  function automatic logic [7:0] shift_one(input logic [7:0] d, input logic b);
    return {d[6:0], b};
  endfunction

  // Clock one bit with the target presenting bit b
  task automatic bit_cycle(input logic b);
    slave_sda = b;
    strobe_toggle();
    strobe_toggle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, e;
    logic       b;
    void'($urandom(32'd2718));
    wait_n(5); rst = 1'b0; wait_n(3);
    // R1
    chk("R1 data", data_q, 8'hFF);
    chk("R1 cnt", cnt_q, 0);
    chk("R1 flags", {flag_start, flag_ovf, flag_stop, flag_coll}, 0);
    chk("R1 pins", {scl_oe_low, sda_oe_low}, 0);

    // R2: start condition
    sda_force_low = 1'b1; wait_n(8);
    chk("R2 start flag", flag_start, 1);
    chk("R3 no stop at start", flag_stop, 0);
    scl_drive_val = 1'b0; scl_drive_wr = 1'b1; wait_n(1); scl_drive_wr = 1'b0; wait_n(8);
    chk("R12 drive low", scl_oe_low, 1);
    sda_force_low = 1'b0; wait_n(8);
    // R4: zero clear bits keep flags, load counter
    stat_write(8'h07);
    chk("R4 keep start", flag_start, 1);
    chk("R4 load cnt", cnt_q, 7);
    stat_write(8'hF0);
    chk("R4 clear all", {flag_start, flag_ovf, flag_stop, flag_coll}, 0);
    chk("R4 load zero", cnt_q, 0);

    // R7: data pin follows bit 7
    data_write(8'h00);
    chk("R7 low for 0", sda_oe_low, 1);
    sda_out_en = 1'b0; wait_n(3);
    chk("R7 released when disabled", sda_oe_low, 0);
    sda_out_en = 1'b1;
    data_write(8'hFF);
    chk("R7 released for 1", sda_oe_low, 0);

    // R5 R6 R8: byte writes, looped back through the released target
    for (int k = 0; k < 12; k++) begin
      v = 8'($urandom);
      if (k == 0) v = 8'h80;
      if (k == 1) v = 8'h01;
      slave_sda = 1'b1;
      stat_write(8'hF0);
      data_write(v);
      for (int i = 0; i < 15; i++) strobe_toggle();
      chk("R5 cnt after 15", cnt_q, 15);
      chk("R6 no ovf at 15", flag_ovf, 0);
      strobe_toggle();
      chk("R6 ovf at 16", flag_ovf, 1);
      chk("R5 wrap cnt", cnt_q, 0);
      chk("R8 loopback byte", data_q, v);
      chk("R10 no coll on write", flag_coll, 0);
    end

    // R8: byte reads, driver disabled
    sda_out_en = 1'b0;
    for (int k = 0; k < 12; k++) begin
      v = 8'($urandom);
      stat_write(8'hF0);
      data_write(8'hFF);
      for (int i = 7; i >= 0; i--) bit_cycle(v[i]);
      slave_sda = 1'b1;
      chk("R8 read byte", data_q, v);
      chk("R6 read ovf", flag_ovf, 1);
      chk("R10 no coll when disabled", flag_coll, 0);
    end

    // R9: single bit transfers with preload 14
    for (int k = 0; k < 8; k++) begin
      v = 8'($urandom); b = 1'($urandom);
      stat_write(8'hFE);
      data_write(v);
      e = shift_one(v, b);
      bit_cycle(b);
      slave_sda = 1'b1;
      chk("R9 one bit data", data_q, e);
      chk("R9 one bit ovf", flag_ovf, 1);
      chk("R9 one bit cnt", cnt_q, 0);
    end

    // R10: collision, driving 1 while target pulls 0
    sda_out_en = 1'b1;
    stat_write(8'hFE);
    data_write(8'hFF);
    bit_cycle(1'b0);
    slave_sda = 1'b1;
    chk("R10 coll set", flag_coll, 1);
    stat_write(8'h10);
    chk("R4 coll cleared", flag_coll, 0);

    // R11 R12: clock held low by target
    stat_write(8'hF0);
    slave_scl = 1'b0;
    strobe_toggle();
    chk("R12 toggle releases", scl_oe_low, 0);
    chk("R11 no count while held", cnt_q, 0);
    slave_scl = 1'b1; wait_n(8);
    chk("R11 count on release", cnt_q, 1);
    strobe_toggle();
    chk("R12 toggle pulls", scl_oe_low, 1);
    chk("R5 count fall", cnt_q, 2);

    // R3: stop condition
    stat_write(8'hF0);
    sda_force_low = 1'b1; wait_n(8);
    scl_drive_val = 1'b1; scl_drive_wr = 1'b1; wait_n(1); scl_drive_wr = 1'b0; wait_n(8);
    sda_force_low = 1'b0; wait_n(8);
    chk("R3 stop flag", flag_stop, 1);
    chk("R2 no start at stop", flag_start, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule